// File: doc/BRIEF.md
# Open-Drain General-Purpose I/O Port

This block is a six-pin general-purpose I/O port whose pad drivers can only pull low. Each pin has a data latch that is written over a simple write strobe with a data word. A latch bit of 0 turns on that pin's pull-down. A latch bit of 1 releases the pin, so an external pull-up brings it high. Reading the data word returns the levels actually seen on the pins, one clock after they are sampled. It does not return the latch contents.

A per-pin output enable lets a peripheral take over a pin. While that enable is set, the latch has no effect on the pin. Peripheral data is open-drain as well: 0 pulls the pin low and 1 releases it.

A standby interface gives the power mode and a pin-hold control bit. In stop or watch mode with the hold bit set, every pull-down is switched off and the input path is gated to 0, so a floating pad cannot leak current. Writes to the latch are still accepted during that time. They reach the pins once the clamp is released.

Top module: `odgpio_port`

## Requirements
- R1: After reset every latch bit is 1, so with no peripheral enable set all `pad_pull_low` bits are 0. One clock after reset ends, `bus_rdata` reads the released pins as 6'h3F.
- R2: With no clamp and `per_oe[i]`=0, `pad_pull_low[i]` is the inverse of latch bit i.
- R3: A cycle with `bus_wr`=1 loads `bus_wdata` into the latch at that clock edge. The pin drive changes in the next cycle.
- R4: With no clamp, `bus_rdata` equals `pad_in` as sampled at the previous clock edge.
- R5: With no clamp and `per_oe[i]`=1, `pad_pull_low[i]` is the inverse of `per_out[i]`, whatever latch bit i holds.
- R6: The clamp is active only when `stby_mode` is stop (2'd2) or watch (2'd3) and `stby_pinhold`=1. While it is active, all `pad_pull_low` bits are 0.
- R7: While the clamp is active, the sampled input is 0 for every pin, so `bus_rdata` reads 0 one clock after the clamp begins.
- R8: In run (2'd0) or sleep (2'd1) mode, or when `stby_pinhold`=0, pins keep their normal latch or peripheral function.
- R9: A write made while the clamp is active is held in the latch. It drives the pins as soon as the clamp is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Data latch write strobe |
| bus_wdata | input | 6 | Data to write into the latch |
| bus_rdata | output | 6 | Sampled pin levels |
| per_oe | input | 6 | Per-pin peripheral output enable |
| per_out | input | 6 | Per-pin peripheral output data (open-drain) |
| stby_mode | input | 2 | Power mode: 0 run, 1 sleep, 2 stop, 3 watch |
| stby_pinhold | input | 1 | Pin-hold control for stop and watch modes |
| pad_pull_low | output | 6 | Per-pin pull-down enable to the pad |
| pad_in | input | 6 | Raw pin level from the pad |

## Verification
The assertions assume that `pad_in` is a synchronous level that the checks can compare one clock later. They also assume that `stby_mode` and `stby_pinhold` change only between clock edges. The bench changes every input on the falling edge. It builds `pad_in` as an open-drain wire from the pull-downs of the block and of a modelled external device, combined with a pull-up. The bench also holds mode and hold steady across each check window, so the clamp cannot toggle in the middle of a sample.

// File: rtl/odgpio_pkg.sv
package odgpio_pkg;

  typedef enum logic [1:0] {
    STBY_RUN   = 2'd0,
    STBY_SLEEP = 2'd1,
    STBY_STOP  = 2'd2,
    STBY_WATCH = 2'd3
  } stby_mode_e;

  // Clamp is active in the deep standby modes when pin hold is requested.
  function automatic logic clamp_active(input logic [1:0] mode, input logic hold);
    return hold && ((mode == STBY_STOP) || (mode == STBY_WATCH));
  endfunction

  // Open-drain drive of one pin: 1 means pull low.
  function automatic logic pin_pull(input logic latch_bit, input logic oe,
                                    input logic pdata, input logic clamp);
    logic src;
    src = oe ? pdata : latch_bit;
    return !clamp && !src;
  endfunction

endpackage

// File: rtl/odgpio_latch.sv
module odgpio_latch #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] q
);
  localparam logic [NUM_PINS-1:0] RESET_VAL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/odgpio_standby.sv
module odgpio_standby (
  input  logic [1:0] mode,
  input  logic       hold,
  output logic       clamp
);
  import odgpio_pkg::*;
  always_comb clamp = clamp_active(mode, hold);
endmodule

// File: rtl/odgpio_pin_mux.sv
module odgpio_pin_mux #(
  parameter int NUM_PINS = 6
) (
  input  logic [NUM_PINS-1:0] latch_q,
  input  logic [NUM_PINS-1:0] oe,
  input  logic [NUM_PINS-1:0] pdata,
  input  logic                clamp,
  output logic [NUM_PINS-1:0] pull_low
);
  import odgpio_pkg::*;
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_comb pull_low[i] = pin_pull(latch_q[i], oe[i], pdata[i], clamp);
  end
endmodule

// File: rtl/odgpio_in_gate.sv
module odgpio_in_gate #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clamp,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] sampled
);
  logic [NUM_PINS-1:0] gated;
  always_comb gated = clamp ? '0 : pad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sampled <= '0;
    else        sampled <= gated;
  end
endmodule

// File: rtl/odgpio_port.sv
module odgpio_port #(
  parameter int NUM_PINS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] per_oe,
  input  logic [NUM_PINS-1:0] per_out,
  input  logic [1:0]          stby_mode,
  input  logic                stby_pinhold,
  output logic [NUM_PINS-1:0] pad_pull_low,
  input  logic [NUM_PINS-1:0] pad_in
);
  logic [NUM_PINS-1:0] latch_q;
  logic                clamp;

  odgpio_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata), .q(latch_q)
  );

  odgpio_standby u_stby (
    .mode(stby_mode), .hold(stby_pinhold), .clamp(clamp)
  );

  odgpio_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .latch_q(latch_q), .oe(per_oe), .pdata(per_out), .clamp(clamp),
    .pull_low(pad_pull_low)
  );

  odgpio_in_gate #(.NUM_PINS(NUM_PINS)) u_gate (
    .clk(clk), .rst_n(rst_n), .clamp(clamp), .pad_in(pad_in), .sampled(bus_rdata)
  );
endmodule

// File: rtl/odgpio_port_chk.sv
module odgpio_port_chk #(
  parameter int NUM_PINS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] bus_rdata,
  input logic [NUM_PINS-1:0] per_oe,
  input logic [NUM_PINS-1:0] per_out,
  input logic [1:0]          stby_mode,
  input logic                stby_pinhold,
  input logic [NUM_PINS-1:0] pad_pull_low,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] latch_q,
  input logic                clamp
);
  p_latch_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp |-> ((pad_pull_low & ~per_oe) == (~latch_q & ~per_oe)));

  p_write_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (latch_q == $past(bus_wdata)));

  p_read_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp |=> (bus_rdata == $past(pad_in)));

  p_periph_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp |-> ((pad_pull_low & per_oe) == (~per_out & per_oe)));

  p_clamp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> (pad_pull_low == '0));

  p_clamp_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |=> (bus_rdata == '0));

  p_no_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_pinhold || !stby_mode[1]) |-> !clamp);
endmodule

bind odgpio_port odgpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .per_oe(per_oe), .per_out(per_out),
  .stby_mode(stby_mode), .stby_pinhold(stby_pinhold),
  .pad_pull_low(pad_pull_low), .pad_in(pad_in),
  .latch_q(latch_q), .clamp(clamp)
);

// File: tb/odgpio_port_tb.sv
`timescale 1ns/1ps
module odgpio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [5:0] bus_wdata = '0;
  logic [5:0] bus_rdata;
  logic [5:0] per_oe = '0;
  logic [5:0] per_out = '0;
  logic [1:0] stby_mode = 2'd0;
  logic       stby_pinhold = 1'b0;
  logic [5:0] pad_pull_low;
  logic [5:0] ext_low = '0;
  logic [5:0] pad_in;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  // Wired-AND pin with pull-up: low if the block or the external device pulls.
  always_comb pad_in = ~(pad_pull_low | ext_low);

  odgpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .per_oe(per_oe), .per_out(per_out),
    .stby_mode(stby_mode), .stby_pinhold(stby_pinhold),
    .pad_pull_low(pad_pull_low), .pad_in(pad_in)
  );

  task automatic check6(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_latch(input logic [5:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
    step();
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    check6("R1 pull_low at reset", pad_pull_low, 6'h00);
    @(negedge clk); rst_n = 1'b1;
    step();
    check6("R1 rdata after reset", bus_rdata, 6'h3F);
  endtask

  task automatic t_write_drive();
    write_latch(6'b101010);
    check6("R2 R3 pull_low after write", pad_pull_low, 6'b010101);
    step();
    check6("R4 rdata of driven pins", bus_rdata, 6'b101010);
    write_latch(6'b000000);
    check6("R2 all pulled low", pad_pull_low, 6'b111111);
    write_latch(6'b111111);
    check6("R2 all released", pad_pull_low, 6'b000000);
  endtask

  task automatic t_read_external();
    @(negedge clk); ext_low = 6'b110001;
    step();
    check6("R4 rdata reads pin not latch", bus_rdata, 6'b001110);
    @(negedge clk); ext_low = 6'b000000;
    step();
    check6("R4 rdata released", bus_rdata, 6'b111111);
  endtask

  task automatic t_peripheral();
    write_latch(6'b000000);
    @(negedge clk); per_oe = 6'b001111; per_out = 6'b000101;
    #1;
    check6("R5 peripheral priority", pad_pull_low, 6'b111010);
    step();
    check6("R5 rdata under peripheral", bus_rdata, 6'b000101);
    @(negedge clk); per_oe = '0; per_out = '0;
    write_latch(6'b111111);
  endtask

  task automatic t_clamp();
    write_latch(6'b000011);
    @(negedge clk); per_oe = 6'b100000; per_out = 6'b000000;
    stby_mode = 2'd2; stby_pinhold = 1'b0;
    #1;
    check6("R8 stop without hold keeps drive", pad_pull_low, 6'b111100);
    @(negedge clk); stby_mode = 2'd1; stby_pinhold = 1'b1;
    #1;
    check6("R8 sleep with hold keeps drive", pad_pull_low, 6'b111100);
    @(negedge clk); stby_mode = 2'd0;
    #1;
    check6("R8 run with hold keeps drive", pad_pull_low, 6'b111100);
    @(negedge clk); stby_mode = 2'd3; ext_low = 6'b000001;
    #1;
    check6("R6 watch with hold forces off", pad_pull_low, 6'b000000);
    step();
    check6("R7 watch input clamped", bus_rdata, 6'b000000);
    @(negedge clk); stby_mode = 2'd2;
    #1;
    check6("R6 stop with hold forces off", pad_pull_low, 6'b000000);
    step();
    check6("R7 stop input clamped", bus_rdata, 6'b000000);
  endtask

  task automatic t_standby_write();
    write_latch(6'b110000);
    check6("R9 write held during clamp", pad_pull_low, 6'b000000);
    @(negedge clk); stby_pinhold = 1'b0; per_oe = '0; ext_low = '0;
    #1;
    check6("R9 write applied after release", pad_pull_low, 6'b001111);
    step();
    check6("R4 rdata after release", bus_rdata, 6'b110000);
    @(negedge clk); stby_mode = 2'd0;
  endtask

  initial begin
    fork
      begin
        step();
        t_reset();
        t_write_drive();
        t_read_external();
        t_peripheral();
        t_clamp();
        t_standby_write();
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule